// File: doc/BRIEF.md
# Adaptive Offset-Dimension Route Selector

This block makes the next-hop port choice for one switch in a two-tier network. Each computing node of a generalized hypercube is a multi-level tree, and every switch in that tree has side links in each hypercube dimension. A request carries four groups of inputs:

- the packet's destination coordinates and the dimension mask the packet carries with it;
- the switch's own coordinates and tree level;
- the least common level (LCL) for the packet;
- idle flags for each dimension's side link, plus queue occupancies for the up, down and side ports.

The block returns a port class, a dimension and the mask that travels onward with the packet. An idle side link in a dimension still to be crossed always wins. Without one, the block picks the shortest queue. Before the LCL the candidates are the up port and the useful side ports; after the LCL they are the down port and the useful side ports. At level 1, past the LCL, the block falls back to dimension order.

Requests and responses use a valid/ready handshake with one register stage. A switch instantiates one selector per input arbitration point and feeds it the live link state.

Top module: `ofs_route_sel`

## Requirements
- R1: The working offset set is the bitwise AND of the carried mask and the set of dimensions whose coordinate fields differ between own and destination (field k sits at bits [k*CW +: CW], dimension 0 lowest). A dimension outside this set is never returned as a side choice.
- R2: With an empty working set, the class is UP (code 0) when the level is below the LCL and DOWN (code 1) otherwise. The returned mask is zero and the dimension is 0.
- R3: If any dimension in the working set has its idle flag set, the class is SIDE (code 2) and the dimension is the lowest such idle dimension.
- R4: With no idle working dimension and level below the LCL, the result is the lowest queue among the up port and the side ports of working dimensions. Ties go to the side port of the lowest dimension, and the up port wins only when it is strictly shorter.
- R5: With no idle working dimension, level at or above the LCL and level not equal to 1, the same shortest-queue rule applies with the down port in place of the up port.
- R6: At level 1, level at or above the LCL and no idle working dimension, the class is SIDE on the lowest-numbered dimension of the working set.
- R7: For a SIDE result the returned mask is the working set with the chosen dimension cleared, so its popcount is one lower. For UP or DOWN the returned mask is the working set unchanged and the dimension is 0.
- R8: req_ready equals (not rsp_valid) or rsp_ready. An accepted request produces rsp_valid and its result on the next clock edge.
- R9: After reset rsp_valid is 0. While rsp_valid is high and rsp_ready is low, every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| dst_coord | input | NDIM*CW | Destination node coordinates |
| carry_mask | input | NDIM | Dimensions still to be crossed, carried with the packet |
| own_coord | input | NDIM*CW | This switch's node coordinates |
| own_level | input | LW | Tree level of this switch (1..NLVL) |
| lcl | input | LW | Least common level for the packet |
| side_idle | input | NDIM | Side link idle, one bit per dimension |
| q_up | input | QW | Up port queue occupancy |
| q_down | input | QW | Down port queue occupancy |
| q_side | input | NDIM*QW | Side port queue occupancies, field k for dimension k |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response accepted |
| rsp_class | output | 2 | 0 UP, 1 DOWN, 2 SIDE |
| rsp_dim | output | DW | Chosen dimension (0 when not SIDE) |
| rsp_mask | output | NDIM | Mask travelling onward |

## Verification
A wrong working set shows up on the next edge after acceptance. The returned mask then carries a bit the packet never needed, or drops one it still needs. A side choice can also land on a dimension whose coordinate already matches. A fault in the idle priority or the queue comparison shows as the wrong class or dimension in that same response cycle. The sweep covers every mask, difference and idle pattern at every level/LCL pair, with queue values that tie often. A broken hold path shows the response changing while rsp_ready is low, one cycle after the new request is offered.

// File: rtl/ors_pkg.sv
package ors_pkg;
   typedef enum logic [1:0] {
      PC_UP   = 2'd0,
      PC_DOWN = 2'd1,
      PC_SIDE = 2'd2
   } port_cls_e;
endpackage

// File: rtl/ors_offset_mask.sv
module ors_offset_mask #(
   parameter int NDIM = 3,
   parameter int CW   = 4
) (
   input  logic [NDIM*CW-1:0] own_coord,
   input  logic [NDIM*CW-1:0] dst_coord,
   input  logic [NDIM-1:0]    carry_mask,
   output logic [NDIM-1:0]    work_mask
);
   logic [NDIM-1:0] differs;

   for (genvar k = 0; k < NDIM; k++) begin : g_dim
      assign differs[k] = own_coord[k*CW +: CW] != dst_coord[k*CW +: CW];
   end

   assign work_mask = differs & carry_mask;
endmodule

// File: rtl/ors_low_pick.sv
module ors_low_pick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

   assign found = |vec;
endmodule

// File: rtl/ors_queue_min.sv
module ors_queue_min #(
   parameter int NDIM = 3,
   parameter int QW   = 8,
   parameter int DW   = 2
) (
   input  logic [NDIM-1:0]    cand,
   input  logic [NDIM*QW-1:0] q_side,
   input  logic [QW-1:0]      q_vert,
   output logic               pick_side,
   output logic [DW-1:0]      pick_dim
);
   logic [QW-1:0] best_q;
   logic          have;

   always_comb begin
      best_q   = '1;
      have     = 1'b0;
      pick_dim = '0;
      for (int k = 0; k < NDIM; k++) begin
         if (cand[k] && (!have || q_side[k*QW +: QW] < best_q)) begin
            best_q   = q_side[k*QW +: QW];
            have     = 1'b1;
            pick_dim = DW'(k);
         end
      end
      pick_side = have && !(q_vert < best_q);
   end
endmodule

// File: rtl/ofs_route_sel.sv
module ofs_route_sel #(
   parameter int NDIM = 3,
   parameter int CW   = 4,
   parameter int NLVL = 3,
   parameter int QW   = 8,
   localparam int DW  = (NDIM > 1) ? $clog2(NDIM) : 1,
   localparam int LW  = $clog2(NLVL + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [NDIM*CW-1:0]   dst_coord,
   input  logic [NDIM-1:0]      carry_mask,
   input  logic [NDIM*CW-1:0]   own_coord,
   input  logic [LW-1:0]        own_level,
   input  logic [LW-1:0]        lcl,
   input  logic [NDIM-1:0]      side_idle,
   input  logic [QW-1:0]        q_up,
   input  logic [QW-1:0]        q_down,
   input  logic [NDIM*QW-1:0]   q_side,
   output logic                 rsp_valid,
   input  logic                 rsp_ready,
   output logic [1:0]           rsp_class,
   output logic [DW-1:0]        rsp_dim,
   output logic [NDIM-1:0]      rsp_mask
);
   import ors_pkg::*;

   if (NDIM < 1) begin : g_bad_ndim
      $error("NDIM must be at least 1");
   end
   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end
   if (NLVL < 1) begin : g_bad_nlvl
      $error("NLVL must be at least 1");
   end
   if (QW < 1) begin : g_bad_qw
      $error("QW must be at least 1");
   end

   logic [NDIM-1:0] work;
   logic [NDIM-1:0] idle_work;
   logic            idle_found;
   logic [DW-1:0]   idle_dim;
   logic            ord_found;
   logic [DW-1:0]   ord_dim;
   logic            q_pick_side;
   logic [DW-1:0]   q_pick_dim;
   logic            below_lcl;
   logic [QW-1:0]   q_vert;

   port_cls_e       nxt_cls;
   logic [DW-1:0]   nxt_dim;
   logic [NDIM-1:0] nxt_mask;

   ors_offset_mask #(.NDIM(NDIM), .CW(CW)) u_offset (
      .own_coord (own_coord),
      .dst_coord (dst_coord),
      .carry_mask(carry_mask),
      .work_mask (work)
   );

   assign idle_work = work & side_idle;

   ors_low_pick #(.N(NDIM), .IW(DW)) u_idle_pick (
      .vec  (idle_work),
      .found(idle_found),
      .idx  (idle_dim)
   );

   ors_low_pick #(.N(NDIM), .IW(DW)) u_order_pick (
      .vec  (work),
      .found(ord_found),
      .idx  (ord_dim)
   );

   assign below_lcl = own_level < lcl;
   assign q_vert    = below_lcl ? q_up : q_down;

   ors_queue_min #(.NDIM(NDIM), .QW(QW), .DW(DW)) u_qmin (
      .cand     (work),
      .q_side   (q_side),
      .q_vert   (q_vert),
      .pick_side(q_pick_side),
      .pick_dim (q_pick_dim)
   );

   always_comb begin
      nxt_dim = '0;
      if (!ord_found) begin
         nxt_cls = below_lcl ? PC_UP : PC_DOWN;
      end else if (idle_found) begin
         nxt_cls = PC_SIDE;
         nxt_dim = idle_dim;
      end else if (below_lcl || own_level != LW'(1)) begin
         if (q_pick_side) begin
            nxt_cls = PC_SIDE;
            nxt_dim = q_pick_dim;
         end else begin
            nxt_cls = below_lcl ? PC_UP : PC_DOWN;
         end
      end else begin
         nxt_cls = PC_SIDE;
         nxt_dim = ord_dim;
      end
      if (nxt_cls == PC_SIDE) nxt_mask = work & ~(NDIM'(1) << nxt_dim);
      else                    nxt_mask = work;
   end

   assign req_ready = !rsp_valid || rsp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_class <= 2'd0;
         rsp_dim   <= '0;
         rsp_mask  <= '0;
      end else if (req_valid && req_ready) begin
         rsp_valid <= 1'b1;
         rsp_class <= nxt_cls;
         rsp_dim   <= nxt_dim;
         rsp_mask  <= nxt_mask;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/ors_checker.sv
module ors_checker #(
   parameter int NDIM = 3,
   parameter int CW   = 4,
   parameter int DW   = 2,
   parameter int LW   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [NDIM*CW-1:0] dst_coord,
   input logic [NDIM-1:0]    carry_mask,
   input logic [NDIM*CW-1:0] own_coord,
   input logic [LW-1:0]      own_level,
   input logic [LW-1:0]      lcl,
   input logic [NDIM-1:0]    side_idle,
   input logic               rsp_valid,
   input logic               rsp_ready,
   input logic [1:0]         rsp_class,
   input logic [DW-1:0]      rsp_dim,
   input logic [NDIM-1:0]    rsp_mask
);
   logic [NDIM-1:0] ck_diff;
   logic            take;

   for (genvar k = 0; k < NDIM; k++) begin : g_d
      assign ck_diff[k] = own_coord[k*CW +: CW] != dst_coord[k*CW +: CW];
   end
   assign take = req_valid && req_ready;

   AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (rsp_mask & ~($past(carry_mask) & $past(ck_diff))) == '0) else $error("mask subset"); // R1
   AST_EMPTY_VERTICAL: assert property (@(posedge clk) disable iff (!rst_n)
      take && (carry_mask & ck_diff) == '0 |=> rsp_class != 2'd2 && rsp_mask == '0) else $error("empty set"); // R2
   AST_IDLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      take && |(carry_mask & ck_diff & side_idle) |=> rsp_class == 2'd2) else $error("idle side"); // R3
   AST_SIDE_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (rsp_class == 2'd2) ->
         ($countones(rsp_mask) + 1 == $countones($past(carry_mask) & $past(ck_diff)))) else $error("side count"); // R7
   AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> rsp_valid) else $error("latency"); // R8
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_class) && $stable(rsp_dim) && $stable(rsp_mask)) else $error("hold"); // R9
endmodule

bind ofs_route_sel ors_checker #(.NDIM(NDIM), .CW(CW), .DW(DW), .LW(LW)) u_ors_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .dst_coord (dst_coord),
   .carry_mask(carry_mask),
   .own_coord (own_coord),
   .own_level (own_level),
   .lcl       (lcl),
   .side_idle (side_idle),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_class (rsp_class),
   .rsp_dim   (rsp_dim),
   .rsp_mask  (rsp_mask)
);

// File: tb/ofs_route_sel_bench.sv
module ofs_route_sel_bench;
   localparam int NDIM = 3;
   localparam int CW   = 4;
   localparam int NLVL = 3;
   localparam int QW   = 8;
   localparam int DW   = 2;
   localparam int LW   = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [NDIM*CW-1:0]  dst_coord = '0;
   logic [NDIM-1:0]     carry_mask = '0;
   logic [NDIM*CW-1:0]  own_coord = '0;
   logic [LW-1:0]       own_level = '0;
   logic [LW-1:0]       lcl = '0;
   logic [NDIM-1:0]     side_idle = '0;
   logic [QW-1:0]       q_up = '0;
   logic [QW-1:0]       q_down = '0;
   logic [NDIM*QW-1:0]  q_side = '0;
   logic                rsp_valid;
   logic                rsp_ready = 1'b1;
   logic [1:0]          rsp_class;
   logic [DW-1:0]       rsp_dim;
   logic [NDIM-1:0]     rsp_mask;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ofs_route_sel #(.NDIM(NDIM), .CW(CW), .NLVL(NLVL), .QW(QW)) u_ofs_route_sel (.*);

   // Expected result from the requirements: class 0 UP, 1 DOWN, 2 SIDE.
   task automatic model(output int cls, output int dim, output int msk, output string tag);
      int work = 0;
      int below;
      int bq;
      int bd;
      int idl;
      for (int k = 0; k < NDIM; k++)
         if (own_coord[k*CW +: CW] != dst_coord[k*CW +: CW] && carry_mask[k]) work |= (1 << k);
      below = (int'(own_level) < int'(lcl)) ? 1 : 0;
      dim = 0;
      idl = work & int'(side_idle);
      if (work == 0) begin
         cls = below ? 0 : 1; tag = "R2";
      end else if (idl != 0) begin
         cls = 2; tag = "R3";
         for (int k = NDIM - 1; k >= 0; k--) if (idl[k]) dim = k;
      end else if (below == 1 || own_level != 1) begin
         tag = below ? "R4" : "R5";
         bq = 1 << 30; bd = 0;
         for (int k = 0; k < NDIM; k++)
            if (work[k] && int'(q_side[k*QW +: QW]) < bq) begin bq = int'(q_side[k*QW +: QW]); bd = k; end
         if (int'(below ? q_up : q_down) < bq) cls = below ? 0 : 1;
         else begin cls = 2; dim = bd; end
      end else begin
         cls = 2; tag = "R6";
         for (int k = NDIM - 1; k >= 0; k--) if (work[k]) dim = k;
      end
      msk = (cls == 2) ? (work & ~(1 << dim)) : work;
   endtask

   task automatic compare(string tag, int ec, int ed, int em);
      n_chk++;
      if (rsp_valid !== 1'b1 || int'(rsp_class) != ec || int'(rsp_dim) != ed || int'(rsp_mask) != em) begin
         n_fail++;
         $display("FAIL %s/R1/R7/R8: got v=%0b cls=%0d dim=%0d mask=%0h exp v=1 cls=%0d dim=%0d mask=%0h",
                  tag, rsp_valid, rsp_class, rsp_dim, rsp_mask, ec, ed, em);
      end
   endtask

   task automatic setup(int n, int cm, int df, int idl, int lv, int lc);
      int own;
      carry_mask = NDIM'(cm);
      side_idle  = NDIM'(idl);
      own_level  = LW'(lv);
      lcl        = LW'(lc);
      for (int k = 0; k < NDIM; k++) begin
         own = (n + 5 * k) % 16;
         own_coord[k*CW +: CW] = CW'(own);
         dst_coord[k*CW +: CW] = CW'(df[k] ? (own ^ ((n % 15) + 1)) : own);
         q_side[k*QW +: QW]    = QW'(((n * 7 + k * 3) % 5) * 10);
      end
      q_up   = QW'(((n * 3) % 5) * 10);
      q_down = QW'(((n * 11 + 2) % 5) * 10);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : stim
      int ec, ed, em, n;
      string tag;
      int hc, hd, hm;
      repeat (3) @(negedge clk);
      // R9 reset state
      n_chk++;
      if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
         n_fail++;
         $display("FAIL R9: got rsp_valid=%0b req_ready=%0b exp 0 1", rsp_valid, req_ready);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n = 0;
      for (int cm = 0; cm < 8; cm++)
         for (int df = 0; df < 8; df++)
            for (int idl = 0; idl < 8; idl++)
               for (int lv = 1; lv <= NLVL; lv++)
                  for (int lc = 1; lc <= NLVL; lc++) begin
                     setup(n, cm, df, idl, lv, lc);
                     req_valid = 1'b1;
                     model(ec, ed, em, tag);
                     @(negedge clk);
                     compare(tag, ec, ed, em);
                     n++;
                  end
      // R9 / R8 hold and backpressure
      setup(3, 7, 7, 0, 2, 3);
      model(hc, hd, hm, tag);
      rsp_ready = 1'b0;
      @(negedge clk);
      compare(tag, hc, hd, hm);
      setup(9, 5, 6, 4, 3, 1);
      model(ec, ed, em, tag);
      @(negedge clk);
      n_chk++;
      if (req_ready !== 1'b0) begin
         n_fail++;
         $display("FAIL R8: got req_ready=%0b exp 0", req_ready);
      end
      compare("R9", hc, hd, hm);
      rsp_ready = 1'b1;
      @(negedge clk);
      compare("R8", ec, ed, em);
      req_valid = 1'b0;
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R8: got rsp_valid=%0b exp 0", rsp_valid);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule